// File: doc/BRIEF.md
# Multichannel Burst Framer with Control Words

This block packs packet traffic from up to 256 logical channels into a single stream of 67-bit line words. Each line word is a 3-bit type prefix followed by a 64-bit payload. The prefix marks the payload as either user data or a control word. Packet data arrives one 64-bit word at a time over a valid/ready handshake. Each input word comes with a channel number, start and end markers, a count of valid bytes for the final word, and an error flag.

The framer cuts each packet into bursts of at most `MAX_BURST` data words. It puts a control word on each side of every burst. One control word can close the burst before it and open the next one. A closing control word reports how the packet ended: the end flag, the valid-byte code and the error flag. An opening control word names the channel and says whether a packet starts. Every control word carries a 16-bit ready mask for flow control, taken from an input port. It also carries a CRC24 that covers the burst just closed and the control word itself.

If a packet has ended and no new data is waiting, the framer emits an idle control word. This word carries the end information and the CRC but does not open a burst. The input is stalled in every cycle in which a control word is produced.

Top module: `burst_framer`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are both 0.
- R2: `out_word[66:64]` is 3'b010 for a data word and 3'b101 for a control word. A control payload holds these fields:
  - bit 63: burst-open flag
  - bit 62: packet-start flag
  - bit 61: packet-end flag
  - bit 60: error flag
  - bits 59:57: valid-byte code
  - bits 56:49: channel
  - bits 48:40: zero
  - bits 39:24: flow-control mask
  - bits 23:0: CRC24
- R3: When no burst is open and `in_valid` is 1, a control word is emitted with the open flag set, the channel taken from `in_chan` and the start flag taken from `in_sop`. The input word is not taken in that cycle; it is taken from the next cycle on.
- R4: Each accepted input word appears unchanged as a data word in the cycle after it is accepted. Data words appear in the order they were accepted.
- R5: After a word with `in_eop` is accepted and its data word is emitted, the next output is a control word with the end flag set. That word carries the error flag from `in_err` and the valid-byte code from `in_nbytes`, where 0 means all 8 bytes.
- R6: If `in_valid` is 1 in the cycle where a burst is closed, the same control word also opens the next burst. If `in_valid` is 0, the word is an idle control word with the open, start and channel fields all zero.
- R7: A burst never holds more than `MAX_BURST` data words. When a packet is longer, a control word with the end flag clear is placed between its bursts. If data is still waiting, that control word reopens on the same channel with the start flag clear.
- R8: The CRC24 uses polynomial 0x328B63 and starts from all ones. It runs MSB first over each data word of the burst just closed, then over the control payload with its CRC field set to zero.
- R9: The flow-control field of each control word equals `fc_ready` in the cycle the word is produced. A 1 bit means that entity is ready to receive.
- R10: `in_ready` is 0 in every cycle that produces a control word. It is also 0 whenever no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word taken at this edge |
| in_data | input | 64 | Packet data word |
| in_chan | input | 8 | Logical channel of the packet |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_nbytes | input | 3 | Valid bytes in the last word (0 = 8) |
| in_err | input | 1 | Packet marked errored (read with in_eop) |
| fc_ready | input | 16 | Per-entity ready mask for the flow-control field |
| out_valid | output | 1 | Line word present |
| out_word | output | 67 | Type prefix and 64-bit payload |

## Verification
The assertions check the following on every cycle:
- an accepted word appears as an unchanged data word one cycle later;
- an end marker is followed, after its data word, by a control word with the end flag set;
- an open burst never reaches the length limit;
- after an idle control word the input stays stalled;
- after an opening control word the input is ready;
- the CRC accumulator is never cleared and updated in the same cycle.

Only the bench scenarios can show that the whole stream is right:
- where the opening, merged, split and idle control words fall;
- the channel and start flags;
- the end-of-packet byte codes;
- the flow-control mask;
- the exact CRC24 over each burst and its control word.

The bench checks these by sweeping packet lengths across the burst limit, both back-to-back and with gaps.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam logic [2:0]  TY_DATA   = 3'b010;
    localparam logic [2:0]  TY_CTRL   = 3'b101;
    localparam logic [23:0] CRC_POLY  = 24'h328B63;
    localparam logic [23:0] CRC_SEED  = 24'hFFFFFF;
    localparam int          CH_W      = 8;
    localparam int          FC_W      = 16;

    typedef struct packed {
        logic            opn;
        logic            sop;
        logic            eop;
        logic            err;
        logic [2:0]      nbytes;
        logic [CH_W-1:0] chan;
        logic [8:0]      rsvd;
        logic [FC_W-1:0] fc;
        logic [23:0]     crc;
    } ctrl_t;

    // Advance a CRC24 over one 64-bit word, most significant bit first.
    function automatic logic [23:0] crc24_step64(input logic [23:0] c_in,
                                                 input logic [63:0] d);
        logic [23:0] c;
        logic        fb;
        c = c_in;
        for (int i = 63; i >= 0; i--) begin
            fb = c[23] ^ d[i];
            c  = {c[22:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/framer_crc_acc.sv
module framer_crc_acc
    import framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        upd,
    input  logic [63:0] data,
    output logic [23:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= CRC_SEED;
        else if (upd)     crc_q <= crc24_step64(crc_q, data);
    end

    // R8
    crc_ops_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(clear && upd));

endmodule

// File: rtl/framer_cw_build.sv
module framer_cw_build
    import framer_pkg::*;
(
    input  logic            opn,
    input  logic            sop,
    input  logic            eop,
    input  logic            err,
    input  logic [2:0]      nbytes,
    input  logic [CH_W-1:0] chan,
    input  logic [FC_W-1:0] fc,
    input  logic [23:0]     crc_run,
    output logic [63:0]     cw
);

    ctrl_t body;

    always_comb begin
        body        = '0;
        body.opn    = opn;
        body.sop    = sop;
        body.eop    = eop;
        body.err    = err;
        body.nbytes = nbytes;
        body.chan   = chan;
        body.fc     = fc;
        body.crc    = crc24_step64(crc_run, body);
        cw          = body;
    end

endmodule

// File: rtl/burst_framer.sv
module burst_framer
    import framer_pkg::*;
#(
    parameter int MAX_BURST = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [63:0]     in_data,
    input  logic [CH_W-1:0] in_chan,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [2:0]      in_nbytes,
    input  logic            in_err,
    input  logic [FC_W-1:0] fc_ready,
    output logic            out_valid,
    output logic [66:0]     out_word
);

    localparam int CNT_W = $clog2(MAX_BURST + 1);

    logic             open_q, pend_q, pend_eop_q, pend_err_q;
    logic [2:0]       pend_nb_q;
    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic             accept, opening, emit_ctrl, close_now;
    logic [23:0]      crc_run;
    logic [63:0]      cw;

    assign in_ready  = open_q;
    assign accept    = in_valid & open_q;
    assign opening   = in_valid & ~open_q;
    assign emit_ctrl = pend_q | opening;
    assign cnt_next  = cnt_q + 1'b1;
    assign close_now = in_eop || (cnt_next == CNT_W'(MAX_BURST));

    framer_crc_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (emit_ctrl),
        .upd   (accept),
        .data  (in_data),
        .crc_q (crc_run)
    );

    framer_cw_build u_cw (
        .opn     (opening),
        .sop     (opening & in_sop),
        .eop     (pend_q & pend_eop_q),
        .err     (pend_q & pend_eop_q & pend_err_q),
        .nbytes  ((pend_q & pend_eop_q) ? pend_nb_q : 3'd0),
        .chan    (opening ? in_chan : '0),
        .fc      (fc_ready),
        .crc_run (crc_run),
        .cw      (cw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            pend_q     <= 1'b0;
            pend_eop_q <= 1'b0;
            pend_err_q <= 1'b0;
            pend_nb_q  <= '0;
            cnt_q      <= '0;
            out_valid  <= 1'b0;
            out_word   <= '0;
        end else begin
            out_valid <= accept | emit_ctrl;
            if (accept) begin
                out_word <= {TY_DATA, in_data};
                cnt_q    <= cnt_next;
                if (close_now) begin
                    open_q     <= 1'b0;
                    pend_q     <= 1'b1;
                    pend_eop_q <= in_eop;
                    pend_err_q <= in_err;
                    pend_nb_q  <= in_nbytes;
                end
            end else if (emit_ctrl) begin
                out_word <= {TY_CTRL, cw};
                pend_q   <= 1'b0;
                open_q   <= opening;
                cnt_q    <= '0;
            end
        end
    end

    // R4
    data_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_word[66:64] == TY_DATA
                                    && out_word[63:0] == $past(in_data)));

    // R5
    eop_close_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_eop) |=> ##1
            (out_valid && out_word[66:64] == TY_CTRL && out_word[61]));

    // R7
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (cnt_q < CNT_W'(MAX_BURST)));

    // R10
    idle_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[66:64] == TY_CTRL && !out_word[63]) |-> !in_ready);

    // R6
    opened_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[66:64] == TY_CTRL && out_word[63]) |-> in_ready);

endmodule

// File: tb/sim_burst_framer.sv
`timescale 1ns/1ps
module sim_burst_framer;

    localparam int MB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [7:0]  in_chan = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic [2:0]  in_nbytes = '0;
    logic [15:0] fc_ready = '0;
    logic        out_valid;
    logic [66:0] out_word;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [66:0] expq[$];
    logic [66:0] rcvq[$];
    int np;
    int p_len[16], p_gap[16], p_chan[16], p_err[16];
    logic [23:0] crc_m;
    logic prev_rdy = 1'b0;

    always #5 clk = ~clk;

    burst_framer #(.MAX_BURST(MB)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_chan(in_chan), .in_sop(in_sop), .in_eop(in_eop),
        .in_nbytes(in_nbytes), .in_err(in_err), .fc_ready(fc_ready),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [23:0] ref_crc(input logic [23:0] c0, input logic [63:0] d);
        logic [23:0] c = c0;
        for (int i = 63; i >= 0; i--) begin
            logic fb = c[23] ^ d[i];
            c = {c[22:0], 1'b0};
            if (fb) c = c ^ 24'h328B63;
        end
        return c;
    endfunction

    function automatic logic [63:0] pdata(input int p, input int i);
        return {32'(p * 1000 + i + 1), 32'(32'hA5A50000 ^ (p * 77 + i * 13))};
    endfunction

    task automatic push_ctrl(input logic st, input logic sp, input logic ep,
                             input logic er, input logic [2:0] nb,
                             input logic [7:0] ch, input logic [15:0] fc);
        logic [63:0] w;
        w = {st, sp, ep, er, nb, ch, 9'b0, fc, 24'b0};
        w[23:0] = ref_crc(crc_m, w);
        expq.push_back({3'b101, w});
        crc_m = 24'hFFFFFF;
    endtask

    task automatic build_expected(input logic [15:0] fc);
        logic pend = 1'b0, pe_err = 1'b0;
        logic [2:0] pe_nb = '0;
        int gap_prev = 1;
        crc_m = 24'hFFFFFF;
        for (int p = 0; p < np; p++) begin
            int cnt = 0;
            if (pend && gap_prev == 0) begin
                push_ctrl(1'b1, 1'b1, 1'b1, pe_err, pe_nb, 8'(p_chan[p]), fc);
            end else begin
                if (pend) push_ctrl(1'b0, 1'b0, 1'b1, pe_err, pe_nb, 8'd0, fc);
                push_ctrl(1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'(p_chan[p]), fc);
            end
            pend = 1'b0;
            for (int i = 0; i < p_len[p]; i++) begin
                expq.push_back({3'b010, pdata(p, i)});
                crc_m = ref_crc(crc_m, pdata(p, i));
                cnt++;
                if (i == p_len[p] - 1) begin
                    pend = 1'b1; pe_err = p_err[p][0]; pe_nb = 3'(p_len[p] % 8);
                end else if (cnt == MB) begin
                    push_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'(p_chan[p]), fc);
                    cnt = 0;
                end
            end
            gap_prev = p_gap[p];
        end
        if (pend) push_ctrl(1'b0, 1'b0, 1'b1, pe_err, pe_nb, 8'd0, fc);
    endtask

    task automatic drive_all();
        for (int p = 0; p < np; p++) begin
            for (int i = 0; i < p_len[p]; i++) begin
                in_valid  = 1'b1;
                in_data   = pdata(p, i);
                in_chan   = 8'(p_chan[p]);
                in_sop    = (i == 0);
                in_eop    = (i == p_len[p] - 1);
                in_err    = p_err[p][0];
                in_nbytes = 3'(p_len[p] % 8);
                while (!in_ready) @(negedge clk);
                @(negedge clk);
            end
            if (p_gap[p] > 0) begin
                in_valid = 1'b0;
                repeat (p_gap[p]) @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    // Monitor: collect the stream; R10 control words only in stalled cycles.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                rcvq.push_back(out_word);
                if (out_word[66:64] == 3'b101) begin
                    total++;
                    if (prev_rdy) begin
                        bad++;
                        $display("FAIL R10: in_ready before control word actual=1 expected=0");
                    end
                end
            end
            prev_rdy = in_ready;
        end
    end

    task automatic compare_stream(input string name);
        total++;
        if (rcvq.size() != expq.size()) begin
            bad++;
            $display("FAIL R6 %s: word count actual=%0d expected=%0d", name, rcvq.size(), expq.size());
        end
        for (int k = 0; k < expq.size() && k < rcvq.size(); k++) begin
            logic [66:0] e = expq[k];
            logic [66:0] g = rcvq[k];
            string tag;
            total++;
            if (e != g) begin
                if (e[66:64] != g[66:64])                 tag = "R2";
                else if (e[66:64] == 3'b010)              tag = "R4";
                else if (e[61:57] != g[61:57])            tag = "R5";
                else if (e[63:62] == 2'b10 && !e[61])     tag = "R7";
                else if (e[63] != g[63])                  tag = "R6";
                else if (e[62] != g[62] || e[56:49] != g[56:49]) tag = "R3";
                else if (e[39:24] != g[39:24])            tag = "R9";
                else                                      tag = "R8";
                bad++;
                $display("FAIL %s %s word %0d: actual=%h expected=%h", tag, name, k, g, e);
            end
        end
        expq.delete();
        rcvq.delete();
    endtask

    task automatic run_scenario(input string name, input logic [15:0] fc);
        fc_ready = fc;
        build_expected(fc);
        drive_all();
        repeat (8) @(negedge clk);
        compare_stream(name);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: cycles actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
            bad++;
            $display("FAIL R1: out_valid/in_ready actual=%b%b expected=00", out_valid, in_ready);
        end
        rst = 1'b0;
        @(negedge clk);

        // Back-to-back packets across the burst limit: merged words (R3, R6, R7, R8)
        np = 10;
        for (int p = 0; p < np; p++) begin
            p_len[p] = p + 1; p_gap[p] = 0; p_chan[p] = p * 17; p_err[p] = p % 2;
        end
        run_scenario("back2back", 16'hFFFF);

        // Same packets with gaps: idle words then fresh openings (R5, R6, R9)
        for (int p = 0; p < np; p++) p_gap[p] = 3;
        run_scenario("gapped", 16'h00A5);

        // Mixed gaps and exact multiples of the burst limit (R7, R8, R9)
        np = 6;
        p_len[0] = 4;  p_len[1] = 8; p_len[2] = 1;
        p_len[3] = 5;  p_len[4] = 12; p_len[5] = 3;
        for (int p = 0; p < np; p++) begin
            p_gap[p] = p % 2; p_chan[p] = 255 - p * 40; p_err[p] = (p == 3) ? 1 : 0;
        end
        run_scenario("mixed", 16'h1234);

        // Single long packet, one gap (R7)
        np = 1; p_len[0] = 17; p_gap[0] = 1; p_chan[0] = 3; p_err[0] = 1;
        run_scenario("long", 16'h8001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule